// File: doc/BRIEF.md
# Parallel Flash Erase Command Controller

This block is the erase side of the command interface of a parallel NOR flash. It watches single-cycle bus writes (address plus data) and recognises two erase commands. Whole-device erase uses a six-write sequence, or a two-write short form once the short-command mode has been entered. Block erase uses the same six-write sequence with a different final data byte. The block has no program, suspend or resume commands and no real cell timing. A behavioural array outside the block does the erasing: the controller sends it a one-cycle request naming a block, waits a fixed number of cycles, and samples the array's fail flag at the end of that wait.

A block erase gathers a list of blocks. After the sequence, a selection window opens. Each further write of 30h during the window adds the block at that write's address and restarts the window. When the window lapses, the engine walks the list in ascending block order. It skips blocks whose protect bit is set when the list closes. If nothing in the list can be erased, the engine stays busy for a short fixed time and then finishes with no data changed and no error. Reads return a status byte, or array data when the read targets a bank that holds no block of the current erase.

A write that breaks the expected sequence sends the decoder back to read mode. While an erase runs, every write is ignored except block additions inside the window. A failed block leaves the controller returning status until a read/reset write (F0h). An active-low hardware reset aborts everything. Window length, per-block erase time and the protected-only busy interval are parameters in clock cycles.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h start a device erase. Command addresses compare the low 11 address bits. `busy` is 1 after the final write. One `erase_req` pulse is issued per unprotected block, in ascending block index. `busy` then returns to 0.
- R2: Writing AAh@555h, 55h@2AAh, 20h@555h enters short-command mode. In that mode, 80h then 10h (any address) starts a device erase, and 80h then 30h starts a block erase of the block at the second write's address.
- R3: The six-write sequence ending in 30h starts a block erase. The sixth write's address bits [ADDR_W-1 -: log2(NUM_BLOCKS)] select the block, and only selected blocks are requested.
- R4: While the selection window is open, a write of 30h adds the block at its address and reloads the window to SEL_TIMEOUT cycles. Additions spaced less than SEL_TIMEOUT apart are all accepted, however long the total.
- R5: Once the window has lapsed (status bit 3 reads 1), a 30h write is refused and its block is not erased.
- R6: Blocks whose `prot` bit is 1 are never requested and keep their data. No error is reported for them, and the controller returns to array reads.
- R7: An erase with no unprotected block in its list holds `busy` for exactly PROT_CYC cycles and issues no `erase_req`.
- R8: During a device erase, every write is ignored, including F0h, B0h and a full new command sequence. The erase completes with each block requested exactly once.
- R9: While an erase is active, a read returns a status byte: bit 7 = 0, bit 6 inverting on each status read, bit 5 = error, bit 3 = 1 once the engine has started (0 while the window is open), other bits 0. During block erase, reads to a bank with no selected block return `arr_rdata`. Read data appears one cycle after `rd_en`.
- R10: If `arr_fail` is 1 at the end of a block's erase time, then after the list ends `busy` is 0 but reads return status with bit 5 = 1, until a write of F0h restores array reads.
- R11: Asserting `rst_n` low aborts an erase: no further `erase_req`, `busy` is 0, and reads return array data. Short-command mode is also cleared.
- R12: A write that does not match the next expected cycle returns the decoder to read mode, so a broken sequence starts nothing. In short-command mode, 90h then 00h leaves the mode, after which 80h, 10h starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, aborts any erase |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | ADDR_W | Bus address for writes and reads |
| wdata | input | DATA_W | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| prot | input | NUM_BLOCKS | Per-block protect bits |
| arr_fail | input | 1 | Array reports failure at the end of a block erase |
| arr_rdata | input | DATA_W | Array content at `addr` |
| rd_data | output | DATA_W | Registered read data, status or array |
| busy | output | 1 | Erase in progress |
| erase_req | output | 1 | One-cycle request to erase block `erase_blk` |
| erase_blk | output | log2(NUM_BLOCKS) | Block to erase |

## Verification
Device erase is driven in three ways: with one protected block, with every block protected, and with stray commands written in the middle. These tell apart correct skipping, the fixed short busy interval, and a decoder that wrongly wakes up during an erase. Block erase is driven with three back-to-back additions, with additions spaced close to the window length so that only a restarting timer accepts them all, and with an addition after the window has closed that must be refused. The short-command forms, a broken unlock sequence, an injected array failure and a mid-erase reset each pin down one decoder path or one way out of an erase.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
   localparam logic [7:0] CMD_UNLK1   = 8'hAA;
   localparam logic [7:0] CMD_UNLK2   = 8'h55;
   localparam logic [7:0] CMD_SETUP   = 8'h80;
   localparam logic [7:0] CMD_DEVICE  = 8'h10;
   localparam logic [7:0] CMD_BLOCK   = 8'h30;
   localparam logic [7:0] CMD_SHORT   = 8'h20;
   localparam logic [7:0] CMD_LEAVE1  = 8'h90;
   localparam logic [7:0] CMD_LEAVE2  = 8'h00;
   localparam logic [7:0] CMD_RDRESET = 8'hF0;

   localparam logic [15:0] ADR_FIRST  = 16'h0555;
   localparam logic [15:0] ADR_SECOND = 16'h02AA;

   localparam int ST_TOGGLE  = 6;
   localparam int ST_ERR     = 5;
   localparam int ST_STARTED = 3;

   typedef enum logic [2:0] {
      D_IDLE, D_U1, D_U2, D_SETUP, D_U4, D_U5, D_SSETUP, D_SLEAVE
   } dec_st_t;

   typedef enum logic [2:0] {
      E_IDLE, E_SEL, E_SCAN, E_WAIT, E_PROT, E_ERR
   } eng_st_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
   import flash_erase_pkg::*;
#(
   parameter int CMD_AW = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [CMD_AW-1:0] addr_lo,
   input  logic [7:0]        wbyte,
   output logic              go_device,
   output logic              go_block,
   output logic              short_mode
);
   dec_st_t st, st_nxt;
   logic    short_nxt;
   logic    at_first, at_second;

   assign at_first  = (addr_lo == ADR_FIRST[CMD_AW-1:0]);
   assign at_second = (addr_lo == ADR_SECOND[CMD_AW-1:0]);

   always_comb begin
      st_nxt    = st;
      short_nxt = short_mode;
      go_device = 1'b0;
      go_block  = 1'b0;
      if (!enable) begin
         st_nxt = D_IDLE;
      end else if (wr_en) begin
         st_nxt = D_IDLE;
         case (st)
            D_IDLE: begin
               if (short_mode) begin
                  if (wbyte == CMD_SETUP)       st_nxt = D_SSETUP;
                  else if (wbyte == CMD_LEAVE1) st_nxt = D_SLEAVE;
               end else if (wbyte == CMD_UNLK1 && at_first) begin
                  st_nxt = D_U1;
               end
            end
            D_U1: if (wbyte == CMD_UNLK2 && at_second) st_nxt = D_U2;
            D_U2: begin
               if (wbyte == CMD_SETUP && at_first)      st_nxt = D_SETUP;
               else if (wbyte == CMD_SHORT && at_first) short_nxt = 1'b1;
            end
            D_SETUP: if (wbyte == CMD_UNLK1 && at_first) st_nxt = D_U4;
            D_U4:    if (wbyte == CMD_UNLK2 && at_second) st_nxt = D_U5;
            D_U5: begin
               if (wbyte == CMD_DEVICE && at_first) go_device = 1'b1;
               else if (wbyte == CMD_BLOCK)         go_block  = 1'b1;
            end
            D_SSETUP: begin
               if (wbyte == CMD_DEVICE)     go_device = 1'b1;
               else if (wbyte == CMD_BLOCK) go_block  = 1'b1;
            end
            D_SLEAVE: if (wbyte == CMD_LEAVE2) short_nxt = 1'b0;
            default: st_nxt = D_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= D_IDLE;
         short_mode <= 1'b0;
      end else begin
         st         <= st_nxt;
         short_mode <= short_nxt;
      end
   end

   // R12
   short_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(short_mode) |-> ($past(st) == D_U2 && $past(wr_en)));
endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
   import flash_erase_pkg::*;
#(
   parameter int NUM_BLOCKS    = 8,
   parameter int SEL_TIMEOUT   = 16,
   parameter int BLK_ERASE_CYC = 6,
   parameter int PROT_CYC      = 5,
   localparam int BLK_W        = $clog2(NUM_BLOCKS),
   localparam int CNT_MAX      = (SEL_TIMEOUT > BLK_ERASE_CYC) ?
                                 ((SEL_TIMEOUT > PROT_CYC) ? SEL_TIMEOUT : PROT_CYC) :
                                 ((BLK_ERASE_CYC > PROT_CYC) ? BLK_ERASE_CYC : PROT_CYC),
   localparam int CNT_W        = $clog2(CNT_MAX + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go_device,
   input  logic                  go_block,
   input  logic                  wr_en,
   input  logic [7:0]            wbyte,
   input  logic [BLK_W-1:0]      wr_blk,
   input  logic [NUM_BLOCKS-1:0] prot,
   input  logic                  arr_fail,
   output eng_st_t               st,
   output logic [NUM_BLOCKS-1:0] sel,
   output logic                  erase_req,
   output logic [BLK_W-1:0]      erase_blk
);
   localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

   logic [NUM_BLOCKS-1:0] elig;
   logic [CNT_W-1:0]      cnt;
   logic [BLK_W-1:0]      idx;
   logic                  fail_seen;
   logic [NUM_BLOCKS-1:0] launch_set;

   assign launch_set = sel & ~prot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= E_IDLE;
         sel       <= '0;
         elig      <= '0;
         cnt       <= '0;
         idx       <= '0;
         fail_seen <= 1'b0;
         erase_req <= 1'b0;
         erase_blk <= '0;
      end else begin
         erase_req <= 1'b0;
         case (st)
            E_IDLE: begin
               fail_seen <= 1'b0;
               idx       <= '0;
               if (go_device) begin
                  sel  <= '1;
                  elig <= ~prot;
                  if (~prot == '0) begin
                     st  <= E_PROT;
                     cnt <= CNT_W'(PROT_CYC - 1);
                  end else begin
                     st <= E_SCAN;
                  end
               end else if (go_block) begin
                  sel <= NUM_BLOCKS'(1) << wr_blk;
                  cnt <= CNT_W'(SEL_TIMEOUT - 1);
                  st  <= E_SEL;
               end
            end
            E_SEL: begin
               if (wr_en && wbyte == CMD_BLOCK) begin
                  sel[wr_blk] <= 1'b1;
                  cnt         <= CNT_W'(SEL_TIMEOUT - 1);
               end else if (cnt == '0) begin
                  elig <= launch_set;
                  if (launch_set == '0) begin
                     st  <= E_PROT;
                     cnt <= CNT_W'(PROT_CYC - 1);
                  end else begin
                     st <= E_SCAN;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            E_SCAN: begin
               if (elig[idx]) begin
                  erase_req <= 1'b1;
                  erase_blk <= idx;
                  cnt       <= CNT_W'(BLK_ERASE_CYC - 1);
                  st        <= E_WAIT;
               end else if (idx == LAST_BLK) begin
                  st <= fail_seen ? E_ERR : E_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            E_WAIT: begin
               if (cnt == '0) begin
                  if (arr_fail) fail_seen <= 1'b1;
                  if (idx == LAST_BLK) begin
                     st <= (fail_seen || arr_fail) ? E_ERR : E_IDLE;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= E_SCAN;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            E_PROT: begin
               if (cnt == '0) st <= E_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            E_ERR: begin
               if (wr_en && wbyte == CMD_RDRESET) st <= E_IDLE;
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   // R3
   req_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> sel[erase_blk]);
   // R1
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req);
   // R5
   list_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_SCAN || st == E_WAIT || st == E_PROT) |=> $stable(sel));
   // R7
   prot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_PROT) |=> !erase_req);
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
   import flash_erase_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_BLOCKS = 8,
   parameter int NUM_BANKS  = 2,
   localparam int BANK_IW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int BPB       = NUM_BLOCKS / NUM_BANKS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_en,
   input  logic [BANK_IW-1:0]    rd_bank,
   input  logic                  busy,
   input  logic                  started,
   input  logic                  err_hold,
   input  logic [NUM_BLOCKS-1:0] sel,
   input  logic [DATA_W-1:0]     arr_rdata,
   output logic [DATA_W-1:0]     rd_data
);
   logic [NUM_BANKS-1:0] bank_hit;
   logic                 hit;
   logic                 use_status;
   logic                 tog;
   logic [DATA_W-1:0]    status;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_hit[b] = |sel[b*BPB +: BPB];
   end

   if (NUM_BANKS > 1) begin : g_multi
      assign hit = bank_hit[rd_bank];
   end else begin : g_single
      logic unused_bank;
      assign unused_bank = rd_bank[0];
      assign hit = bank_hit[0];
   end

   assign use_status = err_hold || (busy && hit);

   always_comb begin
      status             = '0;
      status[ST_TOGGLE]  = tog;
      status[ST_ERR]     = err_hold;
      status[ST_STARTED] = started;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         tog     <= 1'b0;
      end else if (rd_en) begin
         if (use_status) begin
            rd_data <= status;
            tog     <= ~tog;
         end else begin
            rd_data <= arr_rdata;
         end
      end
   end

   // R10
   err_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && err_hold) |=> rd_data[ST_ERR]);
   // R9
   toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && use_status) |=> (rd_data[ST_TOGGLE] != tog));
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
   import flash_erase_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int DATA_W        = 8,
   parameter int CMD_AW        = 11,
   parameter int NUM_BLOCKS    = 8,
   parameter int NUM_BANKS     = 2,
   parameter int SEL_TIMEOUT   = 16,
   parameter int BLK_ERASE_CYC = 6,
   parameter int PROT_CYC      = 5,
   localparam int BLK_W        = $clog2(NUM_BLOCKS),
   localparam int BANK_IW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  rd_en,
   input  logic [NUM_BLOCKS-1:0] prot,
   input  logic                  arr_fail,
   input  logic [DATA_W-1:0]     arr_rdata,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  busy,
   output logic                  erase_req,
   output logic [BLK_W-1:0]      erase_blk
);
   if (DATA_W != 8) begin : g_bad_data
      $error("DATA_W must be 8");
   end
   if (CMD_AW < 10 || CMD_AW > ADDR_W || CMD_AW > 16) begin : g_bad_cmd
      $error("CMD_AW must lie in 10..min(ADDR_W,16)");
   end
   if (NUM_BLOCKS < 2 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_bad_blk
      $error("NUM_BLOCKS must be a power of two of at least 2");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > NUM_BLOCKS || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_bank
      $error("NUM_BANKS must be a power of two not above NUM_BLOCKS");
   end
   if (BLK_W > ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the block index");
   end
   if (SEL_TIMEOUT < 1 || BLK_ERASE_CYC < 1 || PROT_CYC < 1) begin : g_bad_time
      $error("timing parameters must be at least 1");
   end

   eng_st_t               st;
   logic [NUM_BLOCKS-1:0] sel;
   logic                  go_device, go_block, short_mode;
   logic [BLK_W-1:0]      addr_blk;
   logic [BANK_IW-1:0]    rd_bank;
   logic                  started, err_hold;

   assign addr_blk = addr[ADDR_W-1 -: BLK_W];

   if (NUM_BANKS > 1) begin : g_bank_idx
      assign rd_bank = addr[ADDR_W-1 -: BANK_IW];
   end else begin : g_bank_zero
      assign rd_bank = 1'b0;
   end

   flash_cmd_decode #(.CMD_AW(CMD_AW)) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (st == E_IDLE),
      .wr_en      (wr_en),
      .addr_lo    (addr[CMD_AW-1:0]),
      .wbyte      (wdata[7:0]),
      .go_device  (go_device),
      .go_block   (go_block),
      .short_mode (short_mode)
   );

   flash_erase_engine #(
      .NUM_BLOCKS    (NUM_BLOCKS),
      .SEL_TIMEOUT   (SEL_TIMEOUT),
      .BLK_ERASE_CYC (BLK_ERASE_CYC),
      .PROT_CYC      (PROT_CYC)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_device (go_device),
      .go_block  (go_block),
      .wr_en     (wr_en),
      .wbyte     (wdata[7:0]),
      .wr_blk    (addr_blk),
      .prot      (prot),
      .arr_fail  (arr_fail),
      .st        (st),
      .sel       (sel),
      .erase_req (erase_req),
      .erase_blk (erase_blk)
   );

   assign busy     = (st != E_IDLE) && (st != E_ERR);
   assign started  = (st == E_SCAN) || (st == E_WAIT) || (st == E_PROT) || (st == E_ERR);
   assign err_hold = (st == E_ERR);

   flash_read_mux #(
      .DATA_W     (DATA_W),
      .NUM_BLOCKS (NUM_BLOCKS),
      .NUM_BANKS  (NUM_BANKS)
   ) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_bank   (rd_bank),
      .busy      (busy),
      .started   (started),
      .err_hold  (err_hold),
      .sel       (sel),
      .arr_rdata (arr_rdata),
      .rd_data   (rd_data)
   );

   // R1
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> busy);
   // R8
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (go_device || go_block)) |-> 1'b0);
   // R12
   short_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(short_mode));
endmodule

// File: tb/flash_erase_ctrl_bench.sv
module flash_erase_ctrl_bench;
   localparam int ADDR_W = 12;
   localparam int NB     = 8;
   localparam int PROT_CYC = 5;
   localparam int SEL_TIMEOUT = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic rd_en = 1'b0;
   logic [NB-1:0] prot = '0;
   logic arr_fail = 1'b0;
   logic [7:0] arr_rdata;
   logic [7:0] rd_data;
   logic busy, erase_req;
   logic [2:0] erase_blk;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [NB-1:0] erased;
   int req_count;
   int order_err;
   int last_blk;

   always #4 clk = ~clk;

   flash_erase_ctrl u_flash_erase_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rd_en(rd_en), .prot(prot), .arr_fail(arr_fail), .arr_rdata(arr_rdata),
      .rd_data(rd_data), .busy(busy), .erase_req(erase_req), .erase_blk(erase_blk)
   );

   assign arr_rdata = erased[addr[11:9]] ? 8'hFF : 8'hA5;

   always @(posedge clk) begin
      if (erase_req) begin
         if (erase_blk <= last_blk[2:0] && last_blk >= 0) order_err = order_err + 1;
         last_blk = erase_blk;
         erased[erase_blk] = 1'b1;
         req_count = req_count + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_model();
      erased = '0;
      req_count = 0;
      order_err = 0;
      last_blk = -1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic seq6(input logic [11:0] a, input logic [7:0] d);
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(a, d);
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [11:0] blk_addr(input int b);
      return 12'(b << 9);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      idle_cycles(2);
      rst_n = 1'b1;
      idle_cycles(1);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk(busy == 1'b0, "R11 reset busy", busy, 0);
      chk(erase_req == 1'b0, "R11 reset erase_req", erase_req, 0);
      rd(blk_addr(0), d);
      chk(d == 8'hA5, "R9 idle read array", d, 8'hA5);
   endtask

   task automatic t_device_erase();
      clear_model();
      prot = 8'b0000_0100;
      seq6(12'h555, 8'h10);
      chk(busy == 1'b1, "R1 busy after final write", busy, 1);
      wait_idle();
      chk(busy == 1'b0, "R1 busy falls", busy, 0);
      chk(erased == 8'hFB, "R6 protected block skipped", erased, 8'hFB);
      chk(order_err == 0, "R1 ascending order", order_err, 0);
      begin
         logic [7:0] d;
         rd(blk_addr(3), d);
         chk(d == 8'hFF, "R1 read mode after erase", d, 8'hFF);
         rd(blk_addr(2), d);
         chk(d == 8'hA5, "R6 protected data kept, no error", d, 8'hA5);
      end
      prot = '0;
   endtask

   task automatic t_device_ignores();
      logic [7:0] d1, d2;
      clear_model();
      seq6(12'h555, 8'h10);
      rd(blk_addr(1), d1);
      rd(blk_addr(6), d2);
      chk(d1[7] == 1'b0 && d1[5] == 1'b0 && d1[3] == 1'b1 && (d1 & 8'h97) == 0,
          "R9 status byte during device erase", d1, 8'h08);
      chk(d1[6] != d2[6], "R9 toggle bit inverts", d2, ~d1);
      wr(12'h555, 8'hF0);
      wr(12'h000, 8'hB0);
      seq6(blk_addr(3), 8'h30);
      chk(busy == 1'b1, "R8 still busy after stray writes", busy, 1);
      wait_idle();
      chk(erased == 8'hFF && req_count == 8, "R8 each block once", req_count, 8);
      idle_cycles(SEL_TIMEOUT + 4);
      chk(busy == 1'b0 && req_count == 8, "R8 no new erase started", req_count, 8);
   endtask

   task automatic t_block_list();
      logic [7:0] d;
      clear_model();
      seq6(blk_addr(5), 8'h30);
      wr(blk_addr(1), 8'h30);
      wr(blk_addr(6), 8'h30);
      rd(blk_addr(5), d);
      chk(d[3] == 1'b0 && d[7] == 1'b0, "R9 window open status bit 3", d, 8'h00);
      wait_idle();
      chk(erased == 8'b0110_0010, "R3 selected blocks only", erased, 8'b0110_0010);
   endtask

   task automatic t_window_restart();
      logic [7:0] d;
      clear_model();
      seq6(blk_addr(4), 8'h30);
      idle_cycles(SEL_TIMEOUT - 5);
      wr(blk_addr(5), 8'h30);
      idle_cycles(SEL_TIMEOUT - 5);
      rd(blk_addr(0), d);
      chk(d == 8'hA5, "R9 other bank reads array", d, 8'hA5);
      wr(blk_addr(6), 8'h30);
      idle_cycles(SEL_TIMEOUT - 5);
      wr(blk_addr(7), 8'h30);
      chk(req_count == 0, "R4 engine not started while additions arrive", req_count, 0);
      wait_idle();
      chk(erased == 8'hF0, "R4 restarted window accepts all", erased, 8'hF0);
   endtask

   task automatic t_refuse_late();
      logic [7:0] d;
      int n = 0;
      clear_model();
      seq6(blk_addr(2), 8'h30);
      d = 8'h00;
      while (d[3] == 1'b0 && n < 60) begin
         rd(blk_addr(2), d);
         n++;
      end
      chk(d[3] == 1'b1, "R5 engine started flag seen", d, 8'h08);
      wr(blk_addr(3), 8'h30);
      wait_idle();
      chk(erased == 8'b0000_0100, "R5 late addition refused", erased, 8'b0000_0100);
   endtask

   task automatic t_all_protected();
      int n = 0;
      clear_model();
      prot = '1;
      seq6(12'h555, 8'h10);
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
      chk(n == PROT_CYC, "R7 short busy interval", n, PROT_CYC);
      chk(req_count == 0, "R7 no erase request", req_count, 0);
      prot = '0;
   endtask

   task automatic t_short_mode();
      clear_model();
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h20);
      wr(12'h123, 8'h80); wr(12'h456, 8'h10);
      chk(busy == 1'b1, "R2 short device erase starts", busy, 1);
      wait_idle();
      chk(erased == 8'hFF, "R2 short device erase all", erased, 8'hFF);
      clear_model();
      wr(12'h000, 8'h80); wr(blk_addr(7), 8'h30);
      wait_idle();
      chk(erased == 8'h80, "R2 short block erase", erased, 8'h80);
      clear_model();
      wr(12'h000, 8'h90); wr(12'h000, 8'h00);
      wr(12'h555, 8'h80); wr(12'h555, 8'h10);
      idle_cycles(3);
      chk(busy == 1'b0 && req_count == 0, "R12 short mode left", req_count, 0);
   endtask

   task automatic t_broken_seq();
      clear_model();
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h00);
      wr(12'h555, 8'h80); wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
      idle_cycles(3);
      chk(busy == 1'b0 && req_count == 0, "R12 broken data cycle", req_count, 0);
      wr(12'h555, 8'hAA); wr(12'h555, 8'h55); wr(12'h555, 8'h80);
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
      idle_cycles(3);
      chk(busy == 1'b0 && req_count == 0, "R12 wrong unlock address", req_count, 0);
   endtask

   task automatic t_error();
      logic [7:0] d;
      clear_model();
      arr_fail = 1'b1;
      seq6(blk_addr(0), 8'h30);
      wait_idle();
      arr_fail = 1'b0;
      chk(busy == 1'b0, "R10 busy low in error", busy, 0);
      rd(blk_addr(6), d);
      chk(d[5] == 1'b1 && d[3] == 1'b1, "R10 status with error bit", d, 8'h28);
      wr(12'h000, 8'hF0);
      rd(blk_addr(0), d);
      chk(d == 8'hFF, "R10 read reset restores array", d, 8'hFF);
   endtask

   task automatic t_hw_abort();
      logic [7:0] d;
      int snap;
      clear_model();
      seq6(12'h555, 8'h10);
      idle_cycles(3);
      rst_n = 1'b0;
      idle_cycles(2);
      snap = req_count;
      rst_n = 1'b1;
      idle_cycles(60);
      chk(req_count == snap && snap == 1, "R11 no requests after reset", req_count, 1);
      chk(busy == 1'b0, "R11 busy cleared", busy, 0);
      rd(blk_addr(7), d);
      chk(d == 8'hA5, "R11 array read after abort", d, 8'hA5);
   endtask

   initial begin
      clear_model();
      do_reset();
      t_reset();
      t_device_erase();
      t_device_ignores();
      t_block_list();
      t_window_restart();
      t_refuse_late();
      t_all_protected();
      t_short_mode();
      t_broken_seq();
      t_error();
      t_hw_abort();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule